// File: doc/BRIEF.md
# Serial Byte Buffer with Watermark Interrupts

This block sits between a processor register bus and the shift engine of a byte-serial controller. It holds one byte queue for outgoing data and one for incoming data. The processor fills the outgoing queue and drains the incoming one over a simple valid/write/address bus. The shift engine pops outgoing bytes and pushes received bytes through dedicated strobes.

Each queue has a programmable watermark. The receive side flags "ready" when enough bytes have arrived. The transmit side flags "needs data" when its occupancy has fallen low enough. Each watermark feeds a pending bit, which can raise the shared interrupt. Each watermark can also drive a DMA request line. A receive overflow and a transfer-done pulse from the shift engine latch their own pending bits. Pending bits are cleared by writing ones. Each queue can be flushed by a reset bit that clears itself.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset, the control word and the occupancy word read 0, `irq` and both DMA request lines are low, `tx_empty` is high and `rx_full` is low.
- R2: Bytes leave each queue in the order they entered. Writing word address 4 pushes `bus_wdata[7:0]` into the transmit queue, and `tx_data` shows the oldest byte while `tx_pop` removes it. Reading word address 5 returns the oldest received byte in bits 7:0 and removes it.
- R3: The occupancy word (address 1, read only) holds the receive count in bits 7:0 and the transmit count in bits 23:16. A full 128-entry queue reads 0x80.
- R4: When `rx_push` arrives while the receive queue is full, the byte is dropped and pending bit 8 (receive overflow) is set.
- R5: Pending bit 0 is set one cycle after the receive count is at or above the receive level, which is control bits 7:0 (the control word is at address 0).
- R6: Pending bit 4 is set one cycle after the transmit count is at or below the transmit level, which is control bits 23:16.
- R7: Writing ones to the pending word (address 3) clears those bits at that edge. A watermark bit whose condition still holds reads 0 for one cycle and is then set again. A receive-overflow or done event that arrives in the same cycle as its clear leaves the bit set. An event bit stays clear once it has been cleared.
- R8: Control bit 15 flushes the receive queue and control bit 31 flushes the transmit queue. A flush bit reads 1 in the cycle after the write, the queue is empty at the next edge, and the bit then reads 0 while the other control fields keep their written values.
- R9: `irq` is high exactly when some pending bit is also set in the enable word (address 2), which uses the same bit positions 0, 4, 8 and 12.
- R10: `rx_dreq` is high while control bit 8 is set and the receive watermark holds. `tx_dreq` is high while control bit 24 is set and the transmit watermark holds.
- R11: A one-cycle `xfer_done` pulse sets pending bit 12.
- R12: A write to the transmit queue while it is full is dropped and changes nothing. A `tx_pop` on an empty queue leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| tx_pop | input | 1 | Shift engine takes a transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Shift engine delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue full |
| xfer_done | input | 1 | Transfer-complete pulse |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The two functions that can meet in one cycle are a write-one clear of a pending bit and the event that sets that same bit. The bench provokes this by driving a clearing write to the pending word and a push into the full receive queue on the same clock. Pending bit 8 must read 1 afterwards. A plain clear with no event must leave it at 0 over two reads. For the level-sensitive receive-ready bit, the bench clears it while its watermark still holds. It must read 0 once and then 1 on the very next read.

// File: rtl/fifo_irq_pkg.sv
`timescale 1ns/1ps
package fifo_irq_pkg;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_PEND = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;

  // compact interrupt index k lives at word bit 4*k
  localparam int unsigned IRQ_N = 4;
  localparam int unsigned K_RXRDY = 0;
  localparam int unsigned K_TXREQ = 1;
  localparam int unsigned K_RXOVF = 2;
  localparam int unsigned K_DONE  = 3;

  typedef struct packed {
    logic       tx_rst;
    logic       tx_dma;
    logic [7:0] tx_lvl;
    logic       rx_rst;
    logic       rx_dma;
    logic [7:0] rx_lvl;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.rx_lvl = w[7:0];
    c.rx_dma = w[8];
    c.rx_rst = w[15];
    c.tx_lvl = w[23:16];
    c.tx_dma = w[24];
    c.tx_rst = w[31];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[7:0]   = c.rx_lvl;
    w[8]     = c.rx_dma;
    w[15]    = c.rx_rst;
    w[23:16] = c.tx_lvl;
    w[24]    = c.tx_dma;
    w[31]    = c.tx_rst;
    return w;
  endfunction

  function automatic logic [31:0] occ_word(input logic [7:0] rxc, input logic [7:0] txc);
    return {8'h00, txc, 8'h00, rxc};
  endfunction

  function automatic logic [31:0] irq_expand(input logic [IRQ_N-1:0] v);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < IRQ_N; k++) w[4*k] = v[k];
    return w;
  endfunction

  function automatic logic [IRQ_N-1:0] irq_compress(input logic [31:0] w);
    logic [IRQ_N-1:0] v;
    for (int k = 0; k < IRQ_N; k++) v[k] = w[4*k];
    return v;
  endfunction

  function automatic logic rx_wm_hit(input logic [7:0] cnt, input logic [7:0] lvl);
    return cnt >= lvl;
  endfunction

  function automatic logic tx_wm_hit(input logic [7:0] cnt, input logic [7:0] lvl);
    return cnt <= lvl;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_drop
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_drop = push & full & ~flush;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R12: occupancy never passes the depth
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4: a push into a full queue leaves the count untouched
  a_r4_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R8: a flush empties the queue at the next edge
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/irq_status.sv
`timescale 1ns/1ps
module irq_status #(
  parameter int unsigned       NB         = 4,
  parameter logic [NB-1:0]     LEVEL_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          clr_wr,
  input  logic [NB-1:0] wbits,
  input  logic [NB-1:0] lvl_cond,
  input  logic [NB-1:0] evt,
  output logic [NB-1:0] en_q,
  output logic [NB-1:0] pend_q,
  output logic          irq
);
  logic [NB-1:0] clr_hit;
  logic          unused_in;

  assign clr_hit   = clr_wr ? wbits : '0;
  assign unused_in = ^{lvl_cond & ~LEVEL_MASK, evt & LEVEL_MASK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wbits;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      // clear takes this edge, the condition re-arms on the next one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q[i] <= 1'b0;
        else if (clr_hit[i]) pend_q[i] <= 1'b0;
        else if (lvl_cond[i]) pend_q[i] <= 1'b1;
      end
      // R7: a cleared watermark bit reads 0 for one cycle
      a_r7_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit[i] |=> !pend_q[i]);
    end else begin : g_event
      // an event in the clearing cycle wins
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q[i] <= 1'b0;
        else if (evt[i])     pend_q[i] <= 1'b1;
        else if (clr_hit[i]) pend_q[i] <= 1'b0;
      end
      // R7: an event is never lost to a simultaneous clear
      a_r7_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> pend_q[i]);
      // R7: an event bit stays clear without a new event
      a_r7_event_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[i] && !evt[i]) |=> !pend_q[i]);
    end
  end

  assign irq = |(en_q & pend_q);

  // R9: nothing enabled means no interrupt
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: rtl/fifo_irq_ctrl.sv
`timescale 1ns/1ps
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  output logic        tx_empty,
  input  logic        rx_push,
  input  logic [7:0]  rx_data,
  output logic        rx_full,
  input  logic        xfer_done,
  output logic        tx_dreq,
  output logic        rx_dreq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // decoded bus events
  logic wr_ctrl, wr_ien, wr_pend, wr_txd, rd_rxd;
  assign wr_ctrl = bus_valid &  bus_write & (bus_addr == A_CTRL);
  assign wr_ien  = bus_valid &  bus_write & (bus_addr == A_IEN);
  assign wr_pend = bus_valid &  bus_write & (bus_addr == A_PEND);
  assign wr_txd  = bus_valid &  bus_write & (bus_addr == A_TXD);
  assign rd_rxd  = bus_valid & ~bus_write & (bus_addr == A_RXD);

  ctrl_t ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= word_to_ctrl(bus_wdata);
    else begin
      ctrl_q.rx_rst <= 1'b0;
      ctrl_q.tx_rst <= 1'b0;
    end
  end

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    tx_cnt8, rx_cnt8, rx_head;
  logic          tx_full_w, tx_drop, rx_empty_w, rx_drop;

  byte_fifo #(.DEPTH(DEPTH), .DW(8), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.tx_rst),
    .push(wr_txd), .din(bus_wdata[7:0]), .pop(tx_pop),
    .dout(tx_data), .count(tx_cnt), .full(tx_full_w), .empty(tx_empty),
    .push_drop(tx_drop)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.rx_rst),
    .push(rx_push), .din(rx_data), .pop(rd_rxd),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty_w),
    .push_drop(rx_drop)
  );

  assign tx_cnt8 = 8'(tx_cnt);
  assign rx_cnt8 = 8'(rx_cnt);

  // watermark events, named for the checks
  logic rx_hit, tx_hit;
  assign rx_hit = rx_wm_hit(rx_cnt8, ctrl_q.rx_lvl);
  assign tx_hit = tx_wm_hit(tx_cnt8, ctrl_q.tx_lvl);

  logic [IRQ_N-1:0] lvl_cond, evt, en_q, pend_q;
  always_comb begin
    lvl_cond          = '0;
    evt               = '0;
    lvl_cond[K_RXRDY] = rx_hit;
    lvl_cond[K_TXREQ] = tx_hit;
    evt[K_RXOVF]      = rx_drop;
    evt[K_DONE]       = xfer_done;
  end

  irq_status #(.NB(IRQ_N), .LEVEL_MASK(4'b0011)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(wr_ien), .clr_wr(wr_pend),
    .wbits(irq_compress(bus_wdata)), .lvl_cond(lvl_cond), .evt(evt),
    .en_q(en_q), .pend_q(pend_q), .irq(irq)
  );

  assign rx_dreq = ctrl_q.rx_dma & rx_hit;
  assign tx_dreq = ctrl_q.tx_dma & tx_hit;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
      A_STAT:  bus_rdata = occ_word(rx_cnt8, tx_cnt8);
      A_IEN:   bus_rdata = irq_expand(en_q);
      A_PEND:  bus_rdata = irq_expand(pend_q);
      A_RXD:   bus_rdata = {24'h0, rx_empty_w ? 8'h00 : rx_head};
      default: bus_rdata = '0;
    endcase
  end

  logic unused_sig;
  assign unused_sig = ^{bus_wdata, tx_full_w, tx_drop};

  // R8: flush bits clear themselves
  a_r8_rx_rst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rx_rst && !wr_ctrl) |=> !ctrl_q.rx_rst);
  a_r8_tx_rst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.tx_rst && !wr_ctrl) |=> !ctrl_q.tx_rst);

  // R4: overflow latches its pending bit
  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !ctrl_q.rx_rst) |=> pend_q[K_RXOVF]);

  // R5: receive-ready only rises after the watermark held
  a_r5_rxrdy_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[K_RXRDY]) |-> $past(rx_hit));

  // R6: transmit request only rises after the watermark held
  a_r6_txreq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[K_TXREQ]) |-> $past(tx_hit));

  // R11: done pulse latches
  a_r11_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> pend_q[K_DONE]);

endmodule

// File: tb/fifo_irq_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_bench;
  localparam int DEPTH = 128;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_IEN = 3'd2,
                         AD_PEND = 3'd3, AD_TXD = 3'd4, AD_RXD = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, tx_pop = 1'b0, tx_empty, rx_push = 1'b0, rx_full, xfer_done = 1'b0;
  logic tx_dreq, rx_dreq;
  logic [7:0] tx_data, rx_data = '0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH)) u_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
    .xfer_done(xfer_done), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    if (txq.size() < DEPTH) txq.push_back(b);
    bus_wr(AD_TXD, {24'h0, b});
  endtask

  task automatic tx_take();
    @(negedge clk); tx_pop = 1'b1;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_data = b;
    if (rxq.size() < DEPTH) rxq.push_back(b);
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  // scoreboard monitor: compares queue heads as the design hands them out
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_pop) begin
      if (txq.size() > 0) chk("R2 tx order", {24'h0, tx_data}, {24'h0, txq.pop_front()});
      else chk("R12 tx empty on pop", {31'h0, tx_empty}, 32'h1);
    end
    if (rst_n && bus_valid && !bus_write && bus_addr == AD_RXD && rxq.size() > 0)
      chk("R2 rx order", bus_rdata, {24'h0, rxq.pop_front()});
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1
    bus_rd(AD_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
    bus_rd(AD_STAT, rd); chk("R1 occupancy", rd, 32'h0);
    chk("R1 outputs", {27'h0, irq, rx_dreq, tx_dreq, tx_empty, rx_full}, 32'b00010);

    // R2 / R3 transmit path
    tx_put(8'h11); tx_put(8'h22); tx_put(8'h33);
    bus_rd(AD_STAT, rd); chk("R3 tx count", rd, 32'h0003_0000);
    repeat (3) tx_take();
    bus_rd(AD_STAT, rd); chk("R3 tx drained", rd, 32'h0);
    tx_take();
    bus_rd(AD_STAT, rd); chk("R12 pop on empty", rd, 32'h0);

    // R5 receive watermark
    bus_wr(AD_CTRL, 32'h0000_0004);
    rx_put(8'hA0); rx_put(8'hA1); rx_put(8'hA2);
    bus_wr(AD_PEND, 32'hFFFF_FFFF);
    bus_rd(AD_PEND, rd); chk("R5 below level", rd & 32'h1, 32'h0);
    rx_put(8'hA3);
    @(posedge clk); #1;
    bus_rd(AD_PEND, rd); chk("R5 at level", rd & 32'h1, 32'h1);
    bus_rd(AD_STAT, rd); chk("R3 rx count", rd, 32'h0000_0004);

    // R6 transmit watermark held at count 0, level 0
    bus_rd(AD_PEND, rd); chk("R6 tx request", rd & 32'h10, 32'h10);

    // R7 level flag re-arms
    bus_wr(AD_PEND, 32'h1);
    bus_rd(AD_PEND, rd); chk("R7 cleared", rd & 32'h1, 32'h0);
    bus_rd(AD_PEND, rd); chk("R7 re-armed", rd & 32'h1, 32'h1);

    // R9 interrupt masking
    bus_wr(AD_IEN, 32'h1);
    chk("R9 enabled irq", {31'h0, irq}, 32'h1);
    bus_wr(AD_IEN, 32'h1000);
    chk("R9 masked irq", {31'h0, irq}, 32'h0);
    bus_wr(AD_IEN, 32'h0);

    // R10 DMA requests
    bus_wr(AD_CTRL, 32'h0000_0104);
    chk("R10 rx dreq on", {31'h0, rx_dreq}, 32'h1);
    bus_wr(AD_CTRL, 32'h0000_0105);
    chk("R10 rx dreq below", {31'h0, rx_dreq}, 32'h0);
    bus_wr(AD_CTRL, 32'h0100_0000);
    chk("R10 tx dreq on", {30'h0, tx_dreq, rx_dreq}, 32'b10);
    tx_put(8'h55);
    chk("R10 tx dreq above", {31'h0, tx_dreq}, 32'h0);
    tx_take();
    chk("R10 tx dreq back", {31'h0, tx_dreq}, 32'h1);
    bus_wr(AD_CTRL, 32'h0);

    // R4 overflow
    for (int i = 0; i < DEPTH - 4; i++) rx_put(8'(i + 16));
    chk("R4 full", {31'h0, rx_full}, 32'h1);
    bus_wr(AD_PEND, 32'h100);
    bus_rd(AD_PEND, rd); chk("R4 no early flag", rd & 32'h100, 32'h0);
    rx_put(8'hEE);
    bus_rd(AD_PEND, rd); chk("R4 overflow flag", rd & 32'h100, 32'h100);
    bus_rd(AD_STAT, rd); chk("R3 full count", rd & 32'hFF, 32'h80);

    // R7 clear and event in one cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AD_PEND; bus_wdata = 32'h100;
    rx_push = 1'b1; rx_data = 8'hEF;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; rx_push = 1'b0;
    bus_rd(AD_PEND, rd); chk("R7 event wins", rd & 32'h100, 32'h100);
    bus_wr(AD_PEND, 32'h100);
    bus_rd(AD_PEND, rd); chk("R7 event clear", rd & 32'h100, 32'h0);
    bus_rd(AD_PEND, rd); chk("R7 event stays clear", rd & 32'h100, 32'h0);

    // R2 receive order, all 128 bytes
    for (int i = 0; i < DEPTH; i++) bus_rd(AD_RXD, rd);
    bus_rd(AD_STAT, rd); chk("R2 rx drained", rd & 32'hFF, 32'h0);

    // R8 receive flush
    rx_put(8'h01); rx_put(8'h02);
    bus_wr(AD_CTRL, 32'h0000_8003);
    bus_rd(AD_CTRL, rd); chk("R8 rx flush visible", rd, 32'h0000_8003);
    bus_rd(AD_CTRL, rd); chk("R8 rx flush selfclear", rd, 32'h0000_0003);
    rxq.delete();
    bus_rd(AD_STAT, rd); chk("R8 rx flushed", rd & 32'hFF, 32'h0);

    // R8 transmit flush
    tx_put(8'h07); tx_put(8'h08);
    bus_wr(AD_CTRL, 32'h8000_0000);
    @(posedge clk); #1;
    txq.delete();
    bus_rd(AD_STAT, rd); chk("R8 tx flushed", rd, 32'h0);
    bus_rd(AD_CTRL, rd); chk("R8 tx flush selfclear", rd, 32'h0);

    // R12 transmit overfill
    for (int i = 0; i <= DEPTH; i++) tx_put(8'(i * 3 + 1));
    bus_rd(AD_STAT, rd); chk("R12 tx capped", rd, 32'h0080_0000);
    for (int i = 0; i < DEPTH; i++) tx_take();
    chk("R12 tx empty after", {31'h0, tx_empty}, 32'h1);

    // R11 done pulse
    @(negedge clk); xfer_done = 1'b1;
    @(posedge clk); #1 xfer_done = 1'b0;
    bus_rd(AD_PEND, rd); chk("R11 done flag", rd & 32'h1000, 32'h1000);
    bus_wr(AD_IEN, 32'h1000);
    chk("R9 done irq", {31'h0, irq}, 32'h1);
    bus_wr(AD_PEND, 32'h1000);
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule